// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and turns five interrupt request lines into a single request to the CPU, plus a vector address. The five sources are two external pins, a timer 0 overflow, a capture/compare unit and one line that the serial port and timer 1 share. Each source passes through its own bit in an 8-bit enable register, and a global enable bit gates all of them together. When several requests are eligible in the same cycle, one fixed order picks the winner. No priority register exists.

The CPU sees `cpu_req` while an eligible request exists. When it answers with `cpu_ack`, the controller returns the winner's 16-bit vector with a one-cycle strobe. It also marks an interrupt as in service and holds the granted source as a one-hot flag. While an interrupt is in service, no further request reaches the CPU. A one-cycle `reti` pulse ends the in-service state.

The two external pins are edge-triggered: a rising edge leaves a pending flag, and acknowledging that source clears it. The three peripheral lines are level-sensitive: they remain pending for as long as the peripheral holds them high. Software can write the enable register as a byte or set and clear a single bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The enable register resets to 0x00. A byte write stores the written data with bits 6 and 2 forced to 0, so a write of 0xFF reads back 0xBB.
- R2: A single-bit write sets or clears the selected bit. A bit write that names position 6 or 2 leaves the register unchanged. A byte write in the same cycle as a bit write takes precedence.
- R3: While bit 7 (global enable) is 0, `cpu_req` stays low, whatever the individual enable bits and pending requests are.
- R4: Source indices are 0 = external pin 0, 1 = timer 0, 2 = external pin 1, 3 = capture/compare, 4 = serial/timer 1. Of the eligible sources, the lowest index wins.
- R5: In the cycle after a taken acknowledge, `vec_valid` is high for exactly one cycle. In that cycle `vec_addr` equals 0x0003 + 8 × index: 0x0003, 0x000B, 0x0013, 0x001B or 0x0023.
- R6: `cpu_req` is high in the same cycle in which a source is pending, enabled by its own bit (index 0→bit 0, 1→bit 1, 2→bit 3, 3→bit 4, 4→bit 5), and globally enabled, with nothing in service. An acknowledge while `cpu_req` is low has no effect.
- R7: A taken acknowledge sets `in_service` and sets `isr_src` to the one-hot index of the winner. Both hold, and `cpu_req` stays low, until a `reti` pulse clears them in the next cycle.
- R8: Sources 0 and 2 are edge-triggered. A rising edge on the line makes the source pending from the next cycle on, even if the line then falls or the source is disabled. Only an acknowledge that grants the source clears its pending flag.
- R9: Sources 1, 3 and 4 are level-sensitive. They are pending exactly while the line is high, and an acknowledge does not clear them.
- R10: After reset, `vec_addr` is 0x0000, and `vec_valid`, `in_service` and `isr_src` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 5 | Raw request lines, index as in R4 |
| en_byte_we | input | 1 | Byte write strobe for the enable register |
| en_wdata | input | 8 | Byte write data |
| en_bit_we | input | 1 | Single-bit write strobe |
| en_bit_idx | input | 3 | Bit position for single-bit write |
| en_bit_val | input | 1 | Value for single-bit write |
| en_rdata | output | 8 | Enable register read data |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | CPU acknowledge |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_addr | output | 16 | Vector of the last granted source |
| vec_valid | output | 1 | One-cycle strobe for a new vector |
| in_service | output | 1 | An interrupt is being serviced |
| isr_src | output | 5 | One-hot source in service |

## Verification
The properties assume that the CPU sends `reti` only as a single-cycle pulse, and that an acknowledge counts only when `cpu_req` is high in the same cycle. Both are treated as part of the CPU's contract. The bench drives every input one time unit after a clock edge, and its directed sequences raise `reti` only after a grant. The random phase also sends stray acknowledges and returns, which R6 and R7 define as harmless.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // source ordering; the index is also the priority rank (0 highest)
   typedef enum logic [2:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_CCU  = 3'd3,
      SRC_SER  = 3'd4
   } irqc_src_e;

   localparam int unsigned IRQC_NSRC = 5;

   // arbiter implementation choice
   localparam int unsigned ARB_SCAN   = 0;
   localparam int unsigned ARB_ISOLATE = 1;

endpackage

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned GLOBAL_BIT = 7,
   parameter int unsigned IDX_W      = $clog2(REG_W),
   parameter logic [NUM_SRC*IDX_W-1:0] EN_BIT_MAP = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_we,
   input  logic [REG_W-1:0]   byte_wdata,
   input  logic               bit_we,
   input  logic [IDX_W-1:0]   bit_idx,
   input  logic               bit_val,
   output logic [REG_W-1:0]   rdata,
   output logic [NUM_SRC-1:0] src_en,
   output logic               glob_en
);

   function automatic logic [REG_W-1:0] impl_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < int'(NUM_SRC); i++) begin
         m[EN_BIT_MAP[i*IDX_W +: IDX_W]] = 1'b1;
      end
      m[GLOBAL_BIT] = 1'b1;
      return m;
   endfunction

   localparam logic [REG_W-1:0] IMPL_MASK = impl_mask();

   logic [REG_W-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (byte_we) begin
         en_q <= byte_wdata & IMPL_MASK;
      end else if (bit_we && IMPL_MASK[bit_idx]) begin
         en_q[bit_idx] <= bit_val;
      end
   end

   assign rdata   = en_q;
   assign glob_en = en_q[GLOBAL_BIT];

   for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_src_en
      assign src_en[g] = en_q[EN_BIT_MAP[g*IDX_W +: IDX_W]];
   end

endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
   parameter int unsigned NUM_SRC = 5,
   parameter logic [NUM_SRC-1:0] EDGE_SRC = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] line,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] pending
);

   for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_src
      if (EDGE_SRC[g]) begin : g_edge
         logic prev_q;
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= line[g];
               // a fresh edge wins over a clear in the same cycle
               if (line[g] && !prev_q) begin
                  pend_q <= 1'b1;
               end else if (clr[g]) begin
                  pend_q <= 1'b0;
               end
            end
         end
         assign pending[g] = pend_q;
      end else begin : g_level
         assign pending[g] = line[g];
      end
   end

endmodule

// File: rtl/irqc_prio_arb.sv
module irqc_prio_arb
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned VARIANT = ARB_SCAN,
   parameter int unsigned SIDX_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] elig,
   output logic               any,
   output logic [NUM_SRC-1:0] grant,
   output logic [SIDX_W-1:0]  win_idx
);

   assign any = |elig;

   if (VARIANT == ARB_SCAN) begin : g_scan
      always_comb begin
         win_idx = '0;
         for (int i = int'(NUM_SRC) - 1; i >= 0; i--) begin
            if (elig[i]) win_idx = SIDX_W'(i);
         end
      end
      assign grant = any ? (NUM_SRC'(1) << win_idx) : '0;
   end else begin : g_isolate
      // lowest set bit isolated by two's complement
      assign grant = elig & (~elig + NUM_SRC'(1));
      always_comb begin
         win_idx = '0;
         for (int i = 0; i < int'(NUM_SRC); i++) begin
            if (grant[i]) win_idx = SIDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irqc_vector_unit.sv
module irqc_vector_unit #(
   parameter int unsigned NUM_SRC  = 5,
   parameter int unsigned VEC_W    = 16,
   parameter int unsigned VEC_BASE = 3,
   parameter int unsigned VEC_STEP = 8,
   parameter int unsigned SIDX_W   = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [SIDX_W-1:0]  win_idx,
   input  logic [NUM_SRC-1:0] win_grant,
   input  logic               reti,
   output logic [VEC_W-1:0]   vec_addr,
   output logic               vec_valid,
   output logic               in_service,
   output logic [NUM_SRC-1:0] isr_src
);

   logic [VEC_W-1:0] vec_next;

   assign vec_next = VEC_W'(VEC_BASE + int'(win_idx) * VEC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_addr   <= '0;
         vec_valid  <= 1'b0;
         in_service <= 1'b0;
         isr_src    <= '0;
      end else begin
         vec_valid <= take;
         if (take) begin
            vec_addr   <= vec_next;
            in_service <= 1'b1;
            isr_src    <= win_grant;
         end else if (reti) begin
            in_service <= 1'b0;
            isr_src    <= '0;
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC     = IRQC_NSRC,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned GLOBAL_BIT  = 7,
   parameter int unsigned VEC_W       = 16,
   parameter int unsigned VEC_BASE    = 3,
   parameter int unsigned VEC_STEP    = 8,
   parameter logic [NUM_SRC*$clog2(REG_W)-1:0] EN_BIT_MAP = 15'b101_100_011_001_000,
   parameter logic [NUM_SRC-1:0] EDGE_SRC = 5'b00101,
   parameter int unsigned ARB_VARIANT = ARB_SCAN
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        irq_line,
   input  logic                      en_byte_we,
   input  logic [REG_W-1:0]          en_wdata,
   input  logic                      en_bit_we,
   input  logic [$clog2(REG_W)-1:0]  en_bit_idx,
   input  logic                      en_bit_val,
   output logic [REG_W-1:0]          en_rdata,
   output logic                      cpu_req,
   input  logic                      cpu_ack,
   input  logic                      reti,
   output logic [VEC_W-1:0]          vec_addr,
   output logic                      vec_valid,
   output logic                      in_service,
   output logic [NUM_SRC-1:0]        isr_src
);

   localparam int unsigned IDX_W  = $clog2(REG_W);
   localparam int unsigned SIDX_W = $clog2(NUM_SRC);
   localparam longint unsigned TOP_VEC = longint'(VEC_BASE) + longint'(NUM_SRC - 1) * VEC_STEP;

   // elaboration-time parameter checks
   initial begin
      if (NUM_SRC < 2) $error("prio_irq_ctrl: NUM_SRC must be at least 2");
      if (GLOBAL_BIT >= REG_W) $error("prio_irq_ctrl: GLOBAL_BIT outside register");
      if (TOP_VEC >= (longint'(1) << VEC_W)) $error("prio_irq_ctrl: vectors exceed VEC_W");
      if (ARB_VARIANT > ARB_ISOLATE) $error("prio_irq_ctrl: unknown ARB_VARIANT");
      for (int i = 0; i < int'(NUM_SRC); i++) begin
         if (int'(EN_BIT_MAP[i*IDX_W +: IDX_W]) == int'(GLOBAL_BIT))
            $error("prio_irq_ctrl: source enable collides with global bit");
      end
   end

   logic [NUM_SRC-1:0] src_en;
   logic               glob_en;
   logic [NUM_SRC-1:0] pending;
   logic [NUM_SRC-1:0] elig;
   logic [NUM_SRC-1:0] grant;
   logic [SIDX_W-1:0]  win_idx;
   logic               any;
   logic               take;
   logic [NUM_SRC-1:0] clr;

   irqc_enable_reg #(
      .REG_W      (REG_W),
      .NUM_SRC    (NUM_SRC),
      .GLOBAL_BIT (GLOBAL_BIT),
      .IDX_W      (IDX_W),
      .EN_BIT_MAP (EN_BIT_MAP)
   ) i_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_we    (en_byte_we),
      .byte_wdata (en_wdata),
      .bit_we     (en_bit_we),
      .bit_idx    (en_bit_idx),
      .bit_val    (en_bit_val),
      .rdata      (en_rdata),
      .src_en     (src_en),
      .glob_en    (glob_en)
   );

   irqc_req_latch #(
      .NUM_SRC  (NUM_SRC),
      .EDGE_SRC (EDGE_SRC)
   ) i_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .line    (irq_line),
      .clr     (clr),
      .pending (pending)
   );

   assign elig = pending & src_en & {NUM_SRC{glob_en && !in_service}};

   irqc_prio_arb #(
      .NUM_SRC (NUM_SRC),
      .VARIANT (ARB_VARIANT),
      .SIDX_W  (SIDX_W)
   ) i_arb (
      .elig    (elig),
      .any     (any),
      .grant   (grant),
      .win_idx (win_idx)
   );

   assign cpu_req = any;
   assign take    = cpu_ack && any;
   assign clr     = take ? grant : '0;

   irqc_vector_unit #(
      .NUM_SRC  (NUM_SRC),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP),
      .SIDX_W   (SIDX_W)
   ) i_vec (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .win_idx    (win_idx),
      .win_grant  (grant),
      .reti       (reti),
      .vec_addr   (vec_addr),
      .vec_valid  (vec_valid),
      .in_service (in_service),
      .isr_src    (isr_src)
   );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned GLOBAL_BIT = 7,
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STEP   = 8,
   parameter logic [REG_W-1:0] UNUSED_MASK = 8'h44
) (
   input logic               clk,
   input logic               rst_n,
   input logic [REG_W-1:0]   en_rdata,
   input logic               cpu_req,
   input logic               cpu_ack,
   input logic               reti,
   input logic [VEC_W-1:0]   vec_addr,
   input logic               vec_valid,
   input logic               in_service,
   input logic [NUM_SRC-1:0] isr_src
);

   localparam int unsigned TOP_VEC = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

   // R1: unused enable positions never hold a 1
   a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rdata & UNUSED_MASK) == '0);

   // R3: global enable off keeps the CPU request low
   a_r3_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_rdata[GLOBAL_BIT] |-> !cpu_req);

   // R5: vector strobe lasts one cycle
   a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);

   // R5: strobed vector lies on the vector grid
   a_r5_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (int'(vec_addr) >= int'(VEC_BASE) && int'(vec_addr) <= int'(TOP_VEC)
                     && ((int'(vec_addr) - int'(VEC_BASE)) % int'(VEC_STEP)) == 0));

   // R6: a taken acknowledge yields strobe and in-service next cycle
   a_r6_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_req) |=> (vec_valid && in_service));

   // R6: acknowledge without request has no strobe
   a_r6_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !cpu_req) |=> !vec_valid);

   // R7: nesting suppressed
   a_r7_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
      in_service |-> !cpu_req);

   // R7: return pulse ends service
   a_r7_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && in_service) |=> !in_service);

   // R7: service holds without a return pulse
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service && !reti) |=> (in_service && $stable(isr_src)));

   // R7: latched source is one-hot and tracks in-service
   a_r7_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_src) && (in_service == (isr_src != '0)));

endmodule

bind prio_irq_ctrl irqc_checker #(
   .NUM_SRC    (NUM_SRC),
   .REG_W      (REG_W),
   .GLOBAL_BIT (GLOBAL_BIT),
   .VEC_W      (VEC_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STEP   (VEC_STEP)
) i_irqc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_rdata   (en_rdata),
   .cpu_req    (cpu_req),
   .cpu_ack    (cpu_ack),
   .reti       (reti),
   .vec_addr   (vec_addr),
   .vec_valid  (vec_valid),
   .in_service (in_service),
   .isr_src    (isr_src)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  irq_line = '0;
   logic        en_byte_we = 1'b0;
   logic [7:0]  en_wdata = '0;
   logic        en_bit_we = 1'b0;
   logic [2:0]  en_bit_idx = '0;
   logic        en_bit_val = 1'b0;
   logic [7:0]  en_rdata;
   logic        cpu_req;
   logic        cpu_ack = 1'b0;
   logic        reti = 1'b0;
   logic [15:0] vec_addr;
   logic        vec_valid;
   logic        in_service;
   logic [4:0]  isr_src;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit cmp_on = 0;

   always #10 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
      .en_byte_we(en_byte_we), .en_wdata(en_wdata),
      .en_bit_we(en_bit_we), .en_bit_idx(en_bit_idx), .en_bit_val(en_bit_val),
      .en_rdata(en_rdata), .cpu_req(cpu_req), .cpu_ack(cpu_ack), .reti(reti),
      .vec_addr(vec_addr), .vec_valid(vec_valid), .in_service(in_service),
      .isr_src(isr_src)
   );

   // ---------------- reference model ----------------
   int          en_map [5] = '{0, 1, 3, 4, 5};
   logic [4:0]  edge_src = 5'b00101;   // R8 / R9 classification
   logic [7:0]  m_en = '0;
   logic [4:0]  m_prev = '0;
   logic [4:0]  m_pend = '0;
   logic        m_insvc = 0;
   logic [4:0]  m_src = '0;
   logic        m_vv = 0;
   logic [15:0] m_vec = '0;

   function automatic logic [4:0] m_elig();
      logic [4:0] e;
      for (int i = 0; i < 5; i++) begin
         logic p;
         p = edge_src[i] ? m_pend[i] : irq_line[i];
         e[i] = p && m_en[en_map[i]] && m_en[7] && !m_insvc;
      end
      return e;
   endfunction

   function automatic int m_winner(logic [4:0] e);
      for (int i = 0; i < 5; i++) if (e[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = '0; m_prev = '0; m_pend = '0; m_insvc = 0;
         m_src = '0; m_vv = 0; m_vec = '0;
      end else begin
         logic [4:0] e;
         int w;
         bit tk;
         e  = m_elig();
         w  = m_winner(e);
         tk = cpu_ack && (w >= 0);
         if (en_byte_we) m_en = en_wdata & 8'hBB;
         else if (en_bit_we && ((8'hBB >> en_bit_idx) & 8'h1) != 0) m_en[en_bit_idx] = en_bit_val;
         for (int i = 0; i < 5; i++) begin
            if (edge_src[i]) begin
               if (irq_line[i] && !m_prev[i]) m_pend[i] = 1'b1;
               else if (tk && w == i) m_pend[i] = 1'b0;
            end
         end
         m_prev = irq_line;
         m_vv = tk;
         if (tk) begin
            m_vec = 16'(3 + 8 * w);
            m_insvc = 1;
            m_src = 5'(1 << w);
         end else if (reti) begin
            m_insvc = 0;
            m_src = '0;
         end
      end
   end

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: %s actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && rst_n && !done) begin
         chk("R1", "en_rdata", en_rdata, m_en);
         chk("R6", "cpu_req", cpu_req, (m_elig() != 0));
         chk("R5", "vec_valid", vec_valid, m_vv);
         chk("R5", "vec_addr", vec_addr, m_vec);
         chk("R7", "in_service", in_service, m_insvc);
         chk("R7", "isr_src", isr_src, m_src);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic look();
      @(negedge clk); #1;
   endtask

   task automatic wr_byte(logic [7:0] v);
      en_byte_we = 1; en_wdata = v; tick(); en_byte_we = 0; look();
   endtask

   task automatic wr_bit(logic [2:0] idx, logic v);
      en_bit_we = 1; en_bit_idx = idx; en_bit_val = v; tick(); en_bit_we = 0; look();
   endtask

   task automatic do_ack();
      cpu_ack = 1; tick(); cpu_ack = 0; look();
   endtask

   task automatic do_reti();
      reti = 1; tick(); reti = 0; look();
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20ns * 100000);
      errors++;
      $display("FAIL watchdog: all requirements, actual timeout, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      look();
      cmp_on = 1;
      // R10 / R1 reset state
      chk("R10", "vec_addr after reset", vec_addr, 16'h0000);
      chk("R10", "vec_valid after reset", vec_valid, 0);
      chk("R10", "in_service after reset", in_service, 0);
      chk("R10", "isr_src after reset", isr_src, 0);
      chk("R1", "enable reset value", en_rdata, 8'h00);

      // R1 byte write masking
      wr_byte(8'hFF);
      chk("R1", "byte write 0xFF", en_rdata, 8'hBB);
      // R2 bit writes
      wr_bit(3'd6, 1'b0);
      chk("R2", "unused bit 6 clear ignored", en_rdata, 8'hBB);
      wr_bit(3'd0, 1'b0);
      chk("R2", "clear bit 0", en_rdata, 8'hBA);
      wr_bit(3'd0, 1'b1);
      chk("R2", "set bit 0", en_rdata, 8'hBB);
      wr_byte(8'h00);
      wr_bit(3'd2, 1'b1);
      chk("R2", "unused bit 2 set ignored", en_rdata, 8'h00);
      en_byte_we = 1; en_wdata = 8'h00; en_bit_we = 1; en_bit_idx = 3'd7; en_bit_val = 1;
      tick(); en_byte_we = 0; en_bit_we = 0; look();
      chk("R2", "byte write beats bit write", en_rdata, 8'h00);

      // R3 global disable
      wr_byte(8'h3B);
      irq_line[1] = 1; tick(); look();
      chk("R3", "cpu_req with global off", cpu_req, 0);
      wr_bit(3'd7, 1'b1);
      chk("R3", "cpu_req after global on", cpu_req, 1);
      chk("R6", "request combinational", cpu_req, 1);

      // R5 / R7 grant and nesting suppression
      do_ack();
      chk("R5", "strobe after ack", vec_valid, 1);
      chk("R5", "timer0 vector", vec_addr, 16'h000B);
      chk("R7", "in service set", in_service, 1);
      chk("R7", "isr_src timer0", isr_src, 5'b00010);
      irq_line[0] = 1; tick(); look();
      chk("R5", "strobe one cycle", vec_valid, 0);
      chk("R7", "no request while in service", cpu_req, 0);
      do_reti();
      chk("R7", "reti clears service", in_service, 0);
      chk("R7", "request back after reti", cpu_req, 1);
      do_ack();
      chk("R4", "ext0 beats timer0", vec_addr, 16'h0003);
      irq_line[0] = 0;
      do_reti();
      do_ack();
      chk("R8", "ext0 cleared by its ack", vec_addr, 16'h000B);
      do_reti();
      chk("R9", "level timer0 survives ack", cpu_req, 1);
      irq_line[1] = 0; tick(); look();
      chk("R9", "level drop ends request", cpu_req, 0);

      // R4 full ladder
      irq_line = 5'b11111; tick(); look();
      for (int i = 0; i < 5; i++) begin
         do_ack();
         chk("R4", "ladder vector", vec_addr, 3 + 8 * i);
         chk("R5", "ladder strobe", vec_valid, 1);
         if (!edge_src[i]) irq_line[i] = 0;
         do_reti();
      end
      chk("R4", "ladder exhausted", cpu_req, 0);
      irq_line = '0; tick(); look();

      // R6 stray acknowledge
      do_ack();
      chk("R6", "stray ack no strobe", vec_valid, 0);
      chk("R6", "stray ack no service", in_service, 0);

      // R8 edge latched while disabled
      wr_byte(8'h80);
      irq_line[2] = 1; tick(); irq_line[2] = 0; look();
      chk("R8", "disabled edge no request", cpu_req, 0);
      wr_bit(3'd3, 1'b1);
      chk("R8", "latched edge requests", cpu_req, 1);
      do_ack();
      chk("R8", "ext1 vector", vec_addr, 16'h0013);
      do_reti();
      chk("R8", "ext1 pending consumed", cpu_req, 0);

      // random phase, model compared every cycle
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 8) irq_line = irq_line ^ 5'(1 << $urandom_range(0, 4));
         cpu_ack = ($urandom_range(0, 99) < 30);
         reti    = ($urandom_range(0, 99) < 12);
         en_byte_we = ($urandom_range(0, 99) < 3);
         en_wdata   = 8'($urandom) | (($urandom_range(0, 3) != 0) ? 8'h80 : 8'h00);
         en_bit_we  = ($urandom_range(0, 99) < 4);
         en_bit_idx = 3'($urandom_range(0, 7));
         en_bit_val = 1'($urandom_range(0, 1));
         tick();
         cpu_ack = 0; reti = 0; en_byte_we = 0; en_bit_we = 0;
         look();
      end
      irq_line = '0;
      do_reti();
      tick(); look();
      finish_run();
   end

endmodule